// File: doc/BRIEF.md
# Interrupt Status and Delivery Unit

This unit keeps one 32-bit word of pending interrupt causes for a device. Cause bits are set from two directions: internal device sources present a set mask and a clear mask each cycle, and host software writes through a small register port to set or to acknowledge bits. Host software reads the word back to find out why the device interrupted. Two sources are already assigned: bit 0 marks completion of the arithmetic engine and bit 8 marks completion of a memory transfer.

The unit delivers the pending state in one of two ways, chosen by the `msi_enable` input. In legacy mode it drives a level-sensitive interrupt line. That line goes high when a set operation leaves the word nonzero. It drops only when a clear operation leaves the word zero. In message mode it emits a one-cycle request pulse for every set operation that leaves the word nonzero. The pulse is meant for the logic that builds the interrupt message. Clearing has no effect on the message side.

Top module: `irq_hub`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status word, `intx` and `msi_req` are all zero after that edge.
- R2: A host write (`host_wr`=1) at offset 0x60 ORs `host_wdata` into the status word at the next clock edge.
- R3: A host write at offset 0x64 clears, at the next clock edge, every status bit that is 1 in `host_wdata`.
- R4: Each cycle the status becomes `(old & ~clear) | set`. Here set is `src_raise` OR'd with any host set mask, and clear is `src_lower` OR'd with any host clear mask. A set and a clear of the same bit in one cycle therefore leave the bit at 1.
- R5: `host_rdata` equals the current status word when `host_addr` is 0x24 and is zero at every other offset. A host write to any offset other than 0x60 and 0x64 leaves the status unchanged.
- R6: With `msi_enable`=1, `msi_req` is high for exactly the cycle after any cycle that holds a set operation whose result is nonzero. A set operation is a host write to 0x60, whatever its data, or a nonzero `src_raise`. Only one pulse is produced per cycle.
- R7: With `msi_enable`=1, clear operations never pulse `msi_req` and never change `intx`.
- R8: With `msi_enable`=0, `intx` rises on the edge that ends a set operation leaving the status nonzero, and `msi_req` stays low.
- R9: With `msi_enable`=0, `intx` falls only on the edge that ends a clear operation leaving the status zero. A clear operation is a host write to 0x64, whatever its data, or a nonzero `src_lower`. `intx` stays high through clears that leave bits set and through idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_raise | input | 32 | Per-cycle set mask from device sources |
| src_lower | input | 32 | Per-cycle clear mask from device sources |
| host_wr | input | 1 | Host write strobe for this cycle |
| host_addr | input | 8 | Host register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational on `host_addr` |
| msi_enable | input | 1 | 1 selects message delivery, 0 selects the legacy line |
| intx | output | 1 | Level-sensitive legacy interrupt line |
| msi_req | output | 1 | One-cycle message request pulse |

## Verification
The status word, `intx` and `msi_req` are all registered, so each of them reflects a stimulus one clock edge after that stimulus. `host_rdata` is combinational on the address, so it shows the updated word in that same cycle once the edge has passed. The bench applies inputs at the falling edge and advances its reference model at the rising edge. It compares all three observable outputs at the next falling edge, which means every result is checked exactly one edge after its cause. Directed sequences cover simultaneous set and clear, set operations with zero masks, and a switch of delivery mode while the line is high. A random phase then exercises mixed traffic.

// File: rtl/irq_hub_pkg.sv
// Shared constants for the interrupt status unit: the host register offsets.
package irq_hub_pkg;
    localparam int unsigned OFF_STATUS = 32'h24;
    localparam int unsigned OFF_RAISE  = 32'h60;
    localparam int unsigned OFF_LOWER  = 32'h64;
endpackage

// File: rtl/irq_hub_regif.sv
// Host register decode. It turns writes at the set and clear offsets into
// masks plus strobes, and it muxes the status word onto the read bus.
// It assumes a single-cycle write strobe and a combinational read.
module irq_hub_regif
    import irq_hub_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] status_q,
    output logic              host_raise_hit,
    output logic              host_lower_hit,
    output logic [DATA_W-1:0] host_raise_mask,
    output logic [DATA_W-1:0] host_lower_mask,
    output logic [DATA_W-1:0] host_rdata
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_RAISE  = ADDR_W'(OFF_RAISE);
    localparam logic [ADDR_W-1:0] A_LOWER  = ADDR_W'(OFF_LOWER);

    // Decode write strobes for the set and clear offsets.
    always_comb begin
        host_raise_hit  = host_wr && (host_addr == A_RAISE);
        host_lower_hit  = host_wr && (host_addr == A_LOWER);
        host_raise_mask = host_raise_hit ? host_wdata : '0;
        host_lower_mask = host_lower_hit ? host_wdata : '0;
    end

    // Read mux: only the status offset returns data.
    always_comb begin
        host_rdata = (host_addr == A_STATUS) ? status_q : '0;
    end
endmodule

// File: rtl/irq_hub_status.sv
// Pending-cause register. Each bit clears first and sets second, so a cause
// that is set and cleared in the same cycle stays pending. The module also
// reports whether this cycle holds set or clear events and whether the next
// value is nonzero.
module irq_hub_status #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_raise,
    input  logic [DATA_W-1:0] src_lower,
    input  logic              host_raise_hit,
    input  logic              host_lower_hit,
    input  logic [DATA_W-1:0] host_raise_mask,
    input  logic [DATA_W-1:0] host_lower_mask,
    output logic [DATA_W-1:0] status_q,
    output logic              raise_ev,
    output logic              lower_ev,
    output logic              next_nz
);
    logic [DATA_W-1:0] set_m;
    logic [DATA_W-1:0] clr_m;
    logic [DATA_W-1:0] status_d;

    // Merge the source and host masks and classify this cycle's events.
    always_comb begin
        set_m    = src_raise | host_raise_mask;
        clr_m    = src_lower | host_lower_mask;
        raise_ev = host_raise_hit || (|src_raise);
        lower_ev = host_lower_hit || (|src_lower);
    end

    // One flop per cause bit: clear has priority below set.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        always_comb status_d[b] = (status_q[b] & ~clr_m[b]) | set_m[b];

        // Hold or update this cause bit.
        always_ff @(posedge clk) begin
            if (!rst_n) status_q[b] <= 1'b0;
            else        status_q[b] <= status_d[b];
        end
    end

    // Flag whether any cause remains pending after this edge.
    always_comb next_nz = |status_d;
endmodule

// File: rtl/irq_hub_deliver.sv
// Delivery stage. In legacy mode it drives a level that a set operation
// raises and a clear operation to zero drops. In message mode it emits a
// one-cycle pulse per set operation. It assumes the event flags describe
// the same edge as next_nz.
module irq_hub_deliver (
    input  logic clk,
    input  logic rst_n,
    input  logic msi_enable,
    input  logic raise_ev,
    input  logic lower_ev,
    input  logic next_nz,
    output logic intx,
    output logic msi_req
);
    // Message pulse: one cycle for each set operation that leaves causes pending.
    always_ff @(posedge clk) begin
        if (!rst_n) msi_req <= 1'b0;
        else        msi_req <= msi_enable && raise_ev && next_nz;
    end

    // Legacy level: set on a set event, released only by a clear event to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intx <= 1'b0;
        end else if (!msi_enable) begin
            if (raise_ev && next_nz)        intx <= 1'b1;
            else if (lower_ev && !next_nz)  intx <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_hub.sv
// Top of the interrupt status unit: host decode, status register, delivery.
// It assumes the host port is synchronous to clk with a one-cycle strobe.
module irq_hub #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_raise,
    input  logic [DATA_W-1:0] src_lower,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              msi_enable,
    output logic              intx,
    output logic              msi_req
);
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] h_set_m;
    logic [DATA_W-1:0] h_clr_m;
    logic              h_set_hit;
    logic              h_clr_hit;
    logic              raise_ev;
    logic              lower_ev;
    logic              next_nz;

    irq_hub_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
        .host_wr         (host_wr),
        .host_addr       (host_addr),
        .host_wdata      (host_wdata),
        .status_q        (status_q),
        .host_raise_hit  (h_set_hit),
        .host_lower_hit  (h_clr_hit),
        .host_raise_mask (h_set_m),
        .host_lower_mask (h_clr_m),
        .host_rdata      (host_rdata)
    );

    irq_hub_status #(.DATA_W(DATA_W)) u_status (
        .clk             (clk),
        .rst_n           (rst_n),
        .src_raise       (src_raise),
        .src_lower       (src_lower),
        .host_raise_hit  (h_set_hit),
        .host_lower_hit  (h_clr_hit),
        .host_raise_mask (h_set_m),
        .host_lower_mask (h_clr_m),
        .status_q        (status_q),
        .raise_ev        (raise_ev),
        .lower_ev        (lower_ev),
        .next_nz         (next_nz)
    );

    irq_hub_deliver u_deliver (
        .clk        (clk),
        .rst_n      (rst_n),
        .msi_enable (msi_enable),
        .raise_ev   (raise_ev),
        .lower_ev   (lower_ev),
        .next_nz    (next_nz),
        .intx       (intx),
        .msi_req    (msi_req)
    );
endmodule

// File: rtl/irq_hub_chk.sv
// Property checker for irq_hub. It sees the ports and the status register and
// rebuilds the event flags from the ports alone.
module irq_hub_chk
    import irq_hub_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] src_raise,
    input logic [DATA_W-1:0] src_lower,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic              msi_enable,
    input logic              intx,
    input logic              msi_req,
    input logic [DATA_W-1:0] status_q
);
    logic raise_any;
    logic lower_any;

    // Port-level view of set and clear operations.
    always_comb begin
        raise_any = (|src_raise) || (host_wr && host_addr == ADDR_W'(OFF_RAISE));
        lower_any = (|src_lower) || (host_wr && host_addr == ADDR_W'(OFF_LOWER));
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0 && !intx && !msi_req));

    a_r2_no_clear_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(lower_any) |-> ((status_q & $past(status_q)) == $past(status_q)));

    a_r6_pulse_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |-> $past(msi_enable));

    a_r6_pulse_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |-> ($past(raise_any) && status_q != '0));

    a_r8_line_rises_on_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intx) |-> ($past(raise_any) && !$past(msi_enable)));

    a_r9_line_falls_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(intx) |-> (status_q == '0 && $past(lower_any) && !$past(msi_enable)));
endmodule

bind irq_hub irq_hub_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_raise  (src_raise),
    .src_lower  (src_lower),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .msi_enable (msi_enable),
    .intx       (intx),
    .msi_req    (msi_req),
    .status_q   (status_q)
);

// File: tb/irq_hub_test.sv
// Bench for irq_hub: a behavioural reference model that is compared on every clock.
module irq_hub_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_raise = '0;
    logic [31:0] src_lower = '0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        msi_enable = 1'b0;
    logic        intx;
    logic        msi_req;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference state
    logic [31:0] m_status = '0;
    logic        m_intx = 1'b0;
    logic        m_msi = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_hub uut (
        .clk(clk), .rst_n(rst_n), .src_raise(src_raise), .src_lower(src_lower),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .msi_enable(msi_enable), .intx(intx), .msi_req(msi_req)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "rdata", host_rdata, (host_addr == 8'h24) ? m_status : 32'h0);
        check(tag, "intx", {31'h0, intx}, {31'h0, m_intx});
        check(tag, "msi_req", {31'h0, msi_req}, {31'h0, m_msi});
    endtask

    // One clock: drive at the falling edge, advance the model at the rising edge, compare at the next fall.
    task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [31:0] sr, input logic [31:0] sl, input logic me,
                       input string tag);
        logic        rev, lev;
        logic [31:0] setm, clrm, nxt;
        host_wr = wr; host_addr = a; host_wdata = d;
        src_raise = sr; src_lower = sl; msi_enable = me;
        @(posedge clk);
        rev  = (wr && a == 8'h60) || (sr != 0);
        lev  = (wr && a == 8'h64) || (sl != 0);
        setm = sr | ((wr && a == 8'h60) ? d : 32'h0);
        clrm = sl | ((wr && a == 8'h64) ? d : 32'h0);
        nxt  = (m_status & ~clrm) | setm;
        m_msi = me && rev && (nxt != 0);
        if (!me) begin
            if (rev && nxt != 0)       m_intx = 1'b1;
            else if (lev && nxt == 0)  m_intx = 1'b0;
        end
        m_status = nxt;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        host_addr = 8'h24;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;

        // Legacy mode
        cyc(1, 8'h60, 32'h1,        0,       0,     0, "R2");
        cyc(0, 8'h24, 0,            0,       0,     0, "R5");
        cyc(0, 8'h24, 0,            32'h100, 0,     0, "R4");
        cyc(1, 8'h64, 32'h1,        0,       0,     0, "R3");
        cyc(1, 8'h24, 32'hffffffff, 0,       0,     0, "R5");
        cyc(0, 8'h10, 0,            0,       0,     0, "R5");
        cyc(0, 8'h24, 0,            0,       32'h100, 0, "R9");
        cyc(0, 8'h24, 0,            32'h1,   0,     0, "R8");
        cyc(1, 8'h64, 32'h1,        32'h1,   0,     0, "R4");
        cyc(1, 8'h64, 32'hffffffff, 0,       0,     0, "R9");
        // Message mode
        cyc(0, 8'h24, 0,            0,       0,     1, "R7");
        cyc(1, 8'h60, 32'h4,        0,       0,     1, "R6");
        cyc(0, 8'h24, 0,            32'h8,   0,     1, "R6");
        cyc(1, 8'h60, 32'h0,        0,       0,     1, "R6");
        cyc(0, 8'h24, 0,            0,       0,     1, "R6");
        cyc(1, 8'h64, 32'hffffffff, 0,       0,     1, "R7");
        cyc(1, 8'h60, 32'h0,        0,       0,     1, "R6");
        // Mode switch while the line is high
        cyc(1, 8'h60, 32'h2,        0,       0,     0, "R8");
        cyc(1, 8'h64, 32'h2,        0,       0,     1, "R7");
        cyc(0, 8'h24, 0,            0,       0,     0, "R9");
        cyc(1, 8'h64, 32'h0,        0,       0,     0, "R9");

        // Mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic [7:0]  a;
            logic [31:0] sr, sl;
            case ($urandom % 4)
                0: a = 8'h24;
                1: a = 8'h60;
                2: a = 8'h64;
                default: a = 8'h10;
            endcase
            sr = (($urandom % 4) == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
            sl = (($urandom % 3) == 0) ? $urandom : 32'h0;
            cyc(($urandom % 2) == 0, a, $urandom & $urandom, sr, sl,
                (i / 100) % 2 == 1, "R4");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule